// File: doc/BRIEF.md
# Sampled PI Current Regulator

The block is a fixed-point proportional-integral regulator meant to close a current loop once per sampling period. On each sample strobe it takes a signed current-error sample, multiplies it by a programmable proportional gain, and adds the result to an integral state. The integral state grows by the error times a programmable digital integral gain. The sum becomes a signed command for a pulse-width modulator.

A run-time mode input selects how the integral path integrates. In rectangular (backward-Euler) mode it uses the present error only. In trapezoidal mode it uses the average of the present and the previous error. The same two gains serve both modes. The digital integral gain is the continuous one multiplied by the sampling period.

A build-time option inserts a one-period register on the command. A command computed from one sample then reaches the modulator only at the following strobe, which models a full-period computation delay. The integral state and the command both saturate to signed limits set by parameters. The integrator stays pinned at a limit rather than winding up beyond it.

Top module: `pi_reg`

## Requirements
- R1: The proportional term is P = (KP·e + 2^(FRAC−1)) >>> FRAC, where KP and the error e are signed two's complement values, the gains carry FRAC fractional bits (FRAC = 12 by default, so 1.0 = 4096), and >>> is an arithmetic (floor) shift.
- R2: With the mode input low (rectangular mode), each strobe adds the increment (KI·e + 2^(FRAC−1)) >>> FRAC to the integral state.
- R3: With the mode input high (trapezoidal mode), the error sum s = e(k) + e(k−1) is formed one bit wider than the error, then shifted right arithmetically by one, and the increment is (KI·s' + 2^(FRAC−1)) >>> FRAC, where s' is the shifted sum.
- R4: The new integral state is the old state plus the increment, clipped to [LIM_LO, LIM_HI]. Once it is clipped it stays at the limit while the increments keep pushing outward, and it leaves the limit at once when an increment pushes inward.
- R5: The computed command is P plus the new integral state, clipped to [LIM_LO, LIM_HI].
- R6: With DELAY = 0, the command output and a one-cycle valid pulse appear on the clock edge that follows the strobe. Valid is low in every cycle that does not follow a strobe.
- R7: With DELAY = 1, the command output after each strobe is the command computed at the previous strobe. It is 0 after the first strobe since reset, and the valid pulse after that first strobe is suppressed.
- R8: In cycles without a strobe, changes on the error, gain and mode inputs leave the command, the integral state and the stored previous error unchanged.
- R9: A synchronous reset sets the integral state, the stored previous error, the output registers and valid to zero.
- R10: The mode input is read at each strobe. A mode change keeps the integral state, and the previous error is stored at every strobe in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | One-cycle pulse, one per sampling period |
| trap_i | input | 1 | Integration rule: 0 rectangular, 1 trapezoidal |
| err_i | input | EW | Signed current-error sample |
| kp_i | input | GW | Signed proportional gain, FRAC fractional bits |
| ki_i | input | GW | Signed digital integral gain, FRAC fractional bits |
| cmd_o | output | AW | Signed modulator command |
| vld_o | output | 1 | Pulse marking a new command |

## Verification
The undelayed variant registers each result once, so its command and valid pulse are due on the first clock edge after the strobe. The bench therefore drives each strobe on a falling edge and reads the outputs on the following falling edge. The delayed variant runs alongside it on the same inputs and is read in that same half-cycle, where it must show the command the model computed one strobe earlier. Idle cycles are sampled the same way to confirm that valid has dropped and that the command has not moved.

// File: rtl/pi_reg.sv
module pi_reg #(
  parameter int EW     = 16,
  parameter int GW     = 16,
  parameter int FRAC   = 12,
  parameter int AW     = 24,
  parameter int LIM_HI = 4000000,
  parameter int LIM_LO = -4000000,
  parameter bit DELAY  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe_i,
  input  logic                 trap_i,
  input  logic signed [EW-1:0] err_i,
  input  logic signed [GW-1:0] kp_i,
  input  logic signed [GW-1:0] ki_i,
  output logic signed [AW-1:0] cmd_o,
  output logic                 vld_o
);
  // AW must hold a rounded product: AW >= GW + EW - FRAC + 1
  localparam int PW = GW + EW + 1;
  localparam int SW = AW + 1;
  localparam longint HALFV = longint'(1) << (FRAC - 1);
  localparam logic signed [PW-1:0] HALF = PW'(HALFV);
  localparam logic signed [SW-1:0] HI = SW'(LIM_HI);
  localparam logic signed [SW-1:0] LO = SW'(LIM_LO);

  logic signed [AW-1:0] integ, cmd_q, i_next, cmd_next;
  logic signed [EW-1:0] eprev;
  logic signed [EW:0]   e_x, p_x, pair, e_avg, i_sel;
  logic signed [SW-1:0] p_term, i_inc;

  function automatic logic signed [SW-1:0] scale(input logic signed [GW-1:0] g,
                                                 input logic signed [EW:0] x);
    logic signed [PW-1:0] pr;
    pr = PW'(g) * PW'(x) + HALF;
    return SW'(pr >>> FRAC);
  endfunction

  function automatic logic signed [AW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > HI) return HI[AW-1:0];
    if (v < LO) return LO[AW-1:0];
    return v[AW-1:0];
  endfunction

  assign e_x   = {err_i[EW-1], err_i};
  assign p_x   = {eprev[EW-1], eprev};
  assign pair  = e_x + p_x;
  assign e_avg = pair >>> 1;
  assign i_sel = trap_i ? e_avg : e_x;

  assign p_term   = scale(kp_i, e_x);
  assign i_inc    = scale(ki_i, i_sel);
  assign i_next   = clip(SW'(integ) + i_inc);
  assign cmd_next = clip(SW'(i_next) + p_term);

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      eprev <= '0;
      cmd_q <= '0;
    end else if (strobe_i) begin
      integ <= i_next;
      eprev <= err_i;
      cmd_q <= cmd_next;
    end
  end

  generate
    if (DELAY) begin : g_delay
      logic signed [AW-1:0] out_q;
      logic                 primed, vq;
      always_ff @(posedge clk) begin
        if (rst) begin
          out_q  <= '0;
          primed <= 1'b0;
          vq     <= 1'b0;
        end else begin
          vq <= strobe_i && primed;
          if (strobe_i) begin
            out_q  <= cmd_q;
            primed <= 1'b1;
          end
        end
      end
      assign cmd_o = out_q;
      assign vld_o = vq;
    end else begin : g_direct
      logic vq;
      always_ff @(posedge clk) begin
        if (rst) vq <= 1'b0;
        else     vq <= strobe_i;
      end
      assign cmd_o = cmd_q;
      assign vld_o = vq;
    end
  endgenerate
endmodule

// File: rtl/pi_reg_chk.sv
module pi_reg_chk #(
  parameter int AW     = 24,
  parameter int LIM_HI = 4000000,
  parameter int LIM_LO = -4000000,
  parameter bit DELAY  = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 strobe,
  input logic                 vld,
  input logic signed [AW-1:0] cmd,
  input logic signed [AW-1:0] integ
);
  p_reset_r9: assert property (@(posedge clk) rst |=> (cmd == '0 && !vld));

  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !vld);

  p_vld_due_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && !DELAY) |=> vld);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !$past(rst)) |=> $stable(cmd) && $stable(integ));

  p_cmd_range_r5: assert property (@(posedge clk) disable iff (rst)
    (longint'(cmd) <= longint'(LIM_HI)) && (longint'(cmd) >= longint'(LIM_LO)));

  p_integ_range_r4: assert property (@(posedge clk) disable iff (rst)
    (longint'(integ) <= longint'(LIM_HI)) && (longint'(integ) >= longint'(LIM_LO)));
endmodule

bind pi_reg pi_reg_chk #(.AW(AW), .LIM_HI(LIM_HI), .LIM_LO(LIM_LO), .DELAY(DELAY)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe_i), .vld(vld_o), .cmd(cmd_o), .integ(integ)
);

// File: tb/sim_pi_reg.sv
`timescale 1ns/1ps
module sim_pi_reg;
  localparam longint HI = 30000;
  localparam longint LO = -30000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, strb = 1'b0, trap = 1'b0;
  logic signed [15:0] err = '0, kp = '0, ki = '0;
  logic signed [23:0] c0, c1;
  logic v0, v1;

  pi_reg #(.LIM_HI(30000), .LIM_LO(-30000), .DELAY(1'b0)) u0 (
    .clk(clk), .rst(rst), .strobe_i(strb), .trap_i(trap), .err_i(err),
    .kp_i(kp), .ki_i(ki), .cmd_o(c0), .vld_o(v0));
  pi_reg #(.LIM_HI(30000), .LIM_LO(-30000), .DELAY(1'b1)) u1 (
    .clk(clk), .rst(rst), .strobe_i(strb), .trap_i(trap), .err_i(err),
    .kp_i(kp), .ki_i(ki), .cmd_o(c1), .vld_o(v1));

  int total = 0, bad = 0;
  bit done = 0;
  longint mi, ep, pc;
  bit primed;

  function automatic longint clip(longint v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  task automatic chk(string r, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; strb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mi = 0; ep = 0; pc = 0; primed = 0;
    chk("R9 cmd", longint'(c0), 0);
    chk("R9 vld", longint'(v0), 0);
    chk("R9 delayed cmd", longint'(c1), 0);
    chk("R9 delayed vld", longint'(v1), 0);
  endtask

  task automatic step(longint e, string r);
    longint p, s, inc, c, dexp;
    p   = (longint'(kp) * e + 2048) >>> 12;
    s   = trap ? ((e + ep) >>> 1) : e;
    inc = (longint'(ki) * s + 2048) >>> 12;
    mi  = clip(mi + inc);
    c   = clip(p + mi);
    ep  = e;
    dexp = pc;
    @(negedge clk); err = 16'(e); strb = 1'b1;
    @(negedge clk); strb = 1'b0;
    chk(r, longint'(c0), c);
    chk("R6 vld", longint'(v0), 1);
    chk("R7 delayed cmd", longint'(c1), dexp);
    chk("R7 delayed vld", longint'(v1), longint'(primed));
    pc = c; primed = 1;
    @(negedge clk);
    chk("R6 vld drops", longint'(v0), 0);
    chk("R6 delayed vld drops", longint'(v1), 0);
  endtask

  task automatic t_euler();
    trap = 1'b0; kp = 16'sd25698; ki = 16'sd737;
    step(1000, "R1 R2 euler");
    step(-500, "R2 euler");
    step(2000, "R5 euler");
    step(0, "R2 euler zero");
    step(-1500, "R1 euler");
  endtask

  task automatic t_trap();
    trap = 1'b1;
    step(800, "R3 trap");
    step(801, "R3 trap odd");
    step(-3, "R3 trap");
    step(-1000, "R3 trap");
    step(1, "R3 trap odd neg");
  endtask

  task automatic t_switch();
    trap = 1'b0; step(1200, "R10 to euler");
    trap = 1'b1; step(-700, "R10 to trap");
    trap = 1'b0; step(333, "R10 back");
    trap = 1'b1; step(-333, "R10 again");
  endtask

  task automatic t_hold();
    longint h0, h1;
    h0 = longint'(c0); h1 = longint'(c1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); err = 16'(i * 777 - 2000); trap = ~trap; kp = 16'(kp + 16'sd5);
    end
    @(negedge clk);
    chk("R8 cmd held", longint'(c0), h0);
    chk("R8 delayed held", longint'(c1), h1);
    chk("R8 vld", longint'(v0), 0);
    kp = 16'sd25698; trap = 1'b0;
    step(100, "R8 state kept");
  endtask

  task automatic t_sat();
    trap = 1'b0; kp = 16'sd4096; ki = 16'sd16384;
    for (int i = 0; i < 4; i++) step(4000, "R5 saturate");
    chk("R5 at limit", longint'(c0), HI);
    step(0, "R4 integrator pinned");
    chk("R4 pinned value", longint'(c0), HI);
    step(-1000, "R4 unwinds");
    for (int i = 0; i < 5; i++) step(-4000, "R5 low limit");
    chk("R5 at low limit", longint'(c0), LO);
    step(0, "R4 pinned low");
  endtask

  task automatic t_reset_mid();
    kp = 16'sd25698; ki = 16'sd737; trap = 1'b1;
    step(1500, "R3 before reset");
    do_reset();
    step(900, "R9 prev error cleared");
  endtask

  initial begin
    do_reset();
    t_euler();
    t_trap();
    t_switch();
    t_hold();
    t_sat();
    t_reset_mid();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule